// File: doc/BRIEF.md
# Processor Status Enable Register

This block is a small control and status register for a processor's internal condition logic. It holds eight interrupt enables, eight hardware condition flags and a 3-bit interrupt level. Software changes it with one 18-bit command word. In a single write that word can set or clear a chosen group of enables, clear or set the same group of flags, and load a new level. Hardware condition sources raise flags through per-flag strobes.

A read strobe captures a packed 36-bit image of the register. The image is presented on the following cycle with a valid pulse. Whenever an enabled flag is set and the level is nonzero, the block drives an interrupt request on the line for that level.

In the command word, bits [11:4] are the shared selection group, and bits 15 down to 12 choose the functions applied to it. Flag index k sits at word bit 4+k. Flag index 6 (word bit 10) is the host-notify flag.

Top module: `status_enable_reg`

## Requirements
- R1: While rst_ni is low, the enables, the flags and the level are all cleared. After reset, irq_o is zero and a read returns an all-zero word.
- R2: Every write (wr_i high at a clock edge) loads the level from command bits [2:0], whatever the other bits hold.
- R3: When command bit 15 is set, the selection group (command bits [11:4]) is ORed into the enables.
- R4: When command bit 14 is set, the selected enables are cleared. If bits 15 and 14 are both set, the set is applied first and the clear second, so the selected enables end cleared.
- R5: When command bit 13 is set, the selected flags are cleared. When command bit 12 is set, the selected flags are set. If both are set, the clear is applied first and the set second, so the selected flags end set.
- R6: A write with neither bit 13 nor bit 12 set leaves the flags unchanged. Hardware strobes are the one exception (R8).
- R7: A write that carries bit 13 or bit 12 forces the host-notify flag (index 6, word bit 10) to zero, even if the write selected it for setting. The only exception is a hardware strobe for that flag in the same cycle.
- R8: hw_set_i[k] high at a clock edge sets flag k. This is applied after any write functions at the same edge.
- R9: rd_i high at an edge captures the state from before that edge into rd_data_o. rd_valid_o pulses one cycle later. The word layout is: enables at bits [29:22], flags at bits [11:4], level at bits [2:0], all other bits zero. rd_data_o holds its value until the next read.
- R10: irq_o[L] is high exactly when the level equals L, L is nonzero, and some flag is set together with its enable. All other irq_o bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Command write strobe |
| wr_data_i | input | 18 | Command word |
| hw_set_i | input | 8 | Per-flag set strobes from hardware |
| rd_i | input | 1 | Read strobe |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_i |
| rd_data_o | output | 36 | Packed read-back word |
| irq_o | output | 8 | One-hot interrupt request by level; bit 0 is never driven high |

## Verification
The properties assume that wr_i, wr_data_i, hw_set_i and rd_i are clean, synchronous levels that are sampled once per edge. They also assume that the hardware strobes are the only way flags change outside writes. The flag-hold and notify-clear properties are therefore made conditional on the strobes being low. The stimulus drives every input at the falling edge and releases it at the next falling edge. Hardware strobes are asserted only in cycles chosen to test them, so the unconditional paths of the properties are reached often.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int CMD_W      = 18;
  localparam int SEL_LSB    = 4;
  localparam int SEL_W      = 8;
  localparam int LVL_W      = 3;
  localparam int NUM_LVL    = 1 << LVL_W;
  localparam int EN_SET_B   = 15;
  localparam int EN_CLR_B   = 14;
  localparam int FL_CLR_B   = 13;
  localparam int FL_SET_B   = 12;
  localparam int NOTIFY_IDX = 6;
  localparam int RD_W       = 2 * CMD_W;

  typedef struct packed {
    logic             en_set;
    logic             en_clr;
    logic             fl_clr;
    logic             fl_set;
    logic [SEL_W-1:0] sel;
    logic [LVL_W-1:0] lvl;
  } cmd_t;
endpackage

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
  import ser_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_t             cmd_o
);
  logic ser_unused;
  assign ser_unused = ^{cmd_i[CMD_W-1:EN_SET_B+1], cmd_i[SEL_LSB-1:LVL_W]};

  always_comb begin
    cmd_o.en_set = cmd_i[EN_SET_B];
    cmd_o.en_clr = cmd_i[EN_CLR_B];
    cmd_o.fl_clr = cmd_i[FL_CLR_B];
    cmd_o.fl_set = cmd_i[FL_SET_B];
    cmd_o.sel    = cmd_i[SEL_LSB +: SEL_W];
    cmd_o.lvl    = cmd_i[LVL_W-1:0];
  end
endmodule

// File: rtl/ser_state.sv
module ser_state
  import ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  cmd_t             cmd_i,
  input  logic [SEL_W-1:0] hw_set_i,
  output logic [SEL_W-1:0] en_o,
  output logic [SEL_W-1:0] fl_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [SEL_W-1:0] en_d, fl_d, fl_w;
  logic [LVL_W-1:0] lvl_d;
  logic             fl_load;

  assign fl_load = wr_i && (cmd_i.fl_clr || cmd_i.fl_set);

  always_comb begin
    en_d  = en_o;
    lvl_d = lvl_o;
    fl_w  = fl_o;
    if (wr_i) begin
      lvl_d = cmd_i.lvl;
      if (cmd_i.en_set) en_d = en_d | cmd_i.sel;
      if (cmd_i.en_clr) en_d = en_d & ~cmd_i.sel;
      if (cmd_i.fl_clr) fl_w = fl_w & ~cmd_i.sel;
      if (cmd_i.fl_set) fl_w = fl_w | cmd_i.sel;
    end
    // a flag reload drops the host-notify flag
    if (fl_load) fl_w[NOTIFY_IDX] = 1'b0;
    fl_d = fl_w | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      fl_o  <= '0;
      lvl_o <= '0;
    end else begin
      en_o  <= en_d;
      fl_o  <= fl_d;
      lvl_o <= lvl_d;
    end
  end

  p_lvl_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> lvl_o == $past(cmd_i.lvl));
  p_en_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.en_set && !cmd_i.en_clr |=> (en_o & $past(cmd_i.sel)) == $past(cmd_i.sel));
  p_en_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i.en_clr |=> (en_o & $past(cmd_i.sel)) == '0);
  p_fl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_load && hw_set_i == '0 |=> $stable(fl_o));
  p_notify_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_load && !hw_set_i[NOTIFY_IDX] |=> !fl_o[NOTIFY_IDX]);
  p_hw_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fl_o & $past(hw_set_i)) == $past(hw_set_i));
endmodule

// File: rtl/ser_irq.sv
module ser_irq
  import ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] en_i,
  input  logic [SEL_W-1:0] fl_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [NUM_LVL-1:0] irq_o
);
  logic pending;
  assign pending = |(en_i & fl_i);

  assign irq_o[0] = 1'b0;
  for (genvar g = 1; g < NUM_LVL; g++) begin : g_lvl
    assign irq_o[g] = pending && (lvl_i == LVL_W'(g));
  end

  p_irq_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  p_irq_lvl0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i == '0 |-> irq_o == '0);
endmodule

// File: rtl/ser_readback.sv
module ser_readback
  import ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] en_i,
  input  logic [SEL_W-1:0] fl_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             rd_valid_o,
  output logic [RD_W-1:0]  rd_data_o
);
  logic [RD_W-1:0] word;

  always_comb begin
    word = '0;
    word[CMD_W + SEL_LSB +: SEL_W] = en_i;
    word[SEL_LSB +: SEL_W]         = fl_i;
    word[LVL_W-1:0]                = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= word;
    end
  end

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
  p_rd_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);
endmodule

// File: rtl/status_enable_reg.sv
module status_enable_reg
  import ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [17:0]       wr_data_i,
  input  logic [7:0]        hw_set_i,
  input  logic              rd_i,
  output logic              rd_valid_o,
  output logic [35:0]       rd_data_o,
  output logic [7:0]        irq_o
);
  cmd_t             cmd;
  logic [SEL_W-1:0] en, fl;
  logic [LVL_W-1:0] lvl;

  ser_cmd_decode u_dec (
    .cmd_i (wr_data_i),
    .cmd_o (cmd)
  );

  ser_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .cmd_i    (cmd),
    .hw_set_i (hw_set_i),
    .en_o     (en),
    .fl_o     (fl),
    .lvl_o    (lvl)
  );

  ser_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .fl_i   (fl),
    .lvl_i  (lvl),
    .irq_o  (irq_o)
  );

  ser_readback u_rb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .en_i       (en),
    .fl_i       (fl),
    .lvl_i      (lvl),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: tb/status_enable_reg_tb_top.sv
`timescale 1ns/1ps
module status_enable_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [17:0] wr_data_i = '0;
  logic [7:0]  hw_set_i = '0;
  logic        rd_i = 1'b0;
  logic        rd_valid_o;
  logic [35:0] rd_data_o;
  logic [7:0]  irq_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_en = '0, m_fl = '0;
  logic [2:0] m_lvl = '0;
  logic [35:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  status_enable_reg dut_i (.*);

  function automatic logic [35:0] pack(logic [7:0] e, logic [7:0] f, logic [2:0] l);
    logic [35:0] w = '0;
    w[29:22] = e; w[11:4] = f; w[2:0] = l;
    return w;
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] r = '0;
    if (m_lvl != 0 && (m_en & m_fl) != 0) r[m_lvl] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update at the edge, expected read pushed
  task automatic cyc(logic w, logic [17:0] d, logic [7:0] hw, logic r, string tag);
    logic [7:0] f;
    wr_i = w; wr_data_i = d; hw_set_i = hw; rd_i = r;
    @(posedge clk_i);
    if (r) begin exp_q.push_back(pack(m_en, m_fl, m_lvl)); tag_q.push_back(tag); end
    f = m_fl;
    if (w) begin
      m_lvl = d[2:0];
      if (d[15]) m_en = m_en | d[11:4];
      if (d[14]) m_en = m_en & ~d[11:4];
      if (d[13]) f = f & ~d[11:4];
      if (d[12]) f = f | d[11:4];
      if (d[13] | d[12]) f[6] = 1'b0;
    end
    m_fl = f | hw;
    @(negedge clk_i);
    wr_i = 1'b0; hw_set_i = '0; rd_i = 1'b0;
    chk({tag, " irq R10"}, {28'd0, irq_o}, {28'd0, exp_irq()});
  endtask

  task automatic rd(string tag);
    cyc(1'b0, '0, '0, 1'b1, tag);
  endtask

  // monitor: compare read results as they appear
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) chk("R9 unexpected read", rd_data_o, '0);
      else chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 irq after reset", {28'd0, irq_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd("R1 reset read");
    cyc(1'b1, 18'o000005, '0, 1'b0, "R2");
    rd("R2 level load");
    cyc(1'b1, 18'o107776, '0, 1'b0, "R3");
    rd("R3 enable set all");
    cyc(1'b1, 18'o040360, '0, 1'b0, "R4");
    rd("R4 enable clear");
    cyc(1'b1, 18'o140017, '0, 1'b0, "R4b");
    rd("R4 set then clear");
    cyc(1'b1, 18'o100360, 8'h05, 1'b0, "R8");
    rd("R8 hw set");
    cyc(1'b1, 18'o007773, '0, 1'b0, "R6");
    rd("R6 flags held");
    cyc(1'b1, 18'o013763, '0, 1'b0, "R5");
    rd("R5 flag set, notify dropped R7");
    cyc(1'b1, 18'o020063, '0, 1'b0, "R5b");
    rd("R5 flag clear");
    cyc(1'b1, 18'o030103, '0, 1'b0, "R5c");
    rd("R5 clear then set");
    cyc(1'b0, '0, 8'h40, 1'b0, "R7a");
    rd("R7 notify raised by hw");
    cyc(1'b1, 18'o020003, '0, 1'b0, "R7");
    rd("R7 notify cleared by reload");
    cyc(1'b1, 18'o010003, 8'h40, 1'b0, "R7c");
    rd("R7 hw strobe wins over reload");
    cyc(1'b1, 18'o000000, '0, 1'b0, "R10");
    rd("R10 level zero");
    cyc(1'b1, 18'o010407, '0, 1'b1, "R9 read before write");
    rd("R9 after write");
    cyc(1'b1, 18'o040777, '0, 1'b0, "R10b");
    cyc(1'b1, 18'o020000, '0, 1'b0, "R10c");
    rd("R9 final");
    repeat (3) @(negedge clk_i);
    chk("R9 queue drained", {35'd0, exp_q.size() != 0}, '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule